// File: doc/BRIEF.md
# Programmable Chip-Select Wait Controller

This block sits beside an external bus sequencer. It decodes each bus access against four programmable address windows. When an access falls in a window, the block drives that window's active-low select line and applies the window's own timing and width attributes. Those attributes are a wait-state count, an 8/16-bit data width, ready-input honouring, a zero-wait burst mode for sequential reads, and an idle recovery clock before switching to another device. An access that matches no enabled window runs with a global set of default attributes, and no select line is asserted.

The sequencer presents an address with a one-clock start strobe qualified by read or write. The block answers with a wait flag while the cycle is stretched and a one-clock done pulse in the final clock of the access. A width output tells the sequencer whether to split a word into two byte cycles.

Window 0 is the boot window. Whether it is live out of reset depends on a strap input, and its width always follows a narrow-bus pin. A select line stays low without a gap when accesses to the same window follow back to back.

Top module: `csel_wait_ctl`

## Requirements
- R1: A window with its enable bit set matches an address A when start <= A < start + 2^size. When several windows match, the lowest-numbered one is used.
- R2: `cs_n` is active low. At most one bit is low at any time, and only while an access to a matching window is in its access phase. An unmatched access leaves all four bits high.
- R3: A cycle accepted at clock edge E0 with wait count W (and no stall) raises `cyc_done` in the clock that follows edge E0+W. `wait_o` is high in the clocks before that and is never high together with `cyc_done`.
- R4: When a window's ready-enable bit is set and its waits have expired, the cycle is held with `cyc_done` low for as long as `rdy` is low.
- R5: `bus16` reports the control bit 4 of the selected window. For window 0 it reports the inverse of `narrow_bus` instead: the pin high means 8-bit, and the register bit is ignored.
- R6: After reset, windows 1 to 3 are disabled. Window 0 has start 0x800000, size code 23, wait 3, and no ready, burst or recovery. Window 0 is enabled only if `boot_ext` is high during reset. The default attributes reset to wait 7 and 8-bit.
- R7: When the bank-0 bit (control bit 9) is set on window 0, 1 or 2, the window's effective start has address bits 23..16 forced to zero. On window 3 that bit has no effect.
- R8: If a new start to the same window is accepted in the `cyc_done` clock, that window's `cs_n` bit stays low through both accesses. Without a new start, all `cs_n` bits are high in the clock after `cyc_done`.
- R9: With burst mode set (control bit 6), an access to the same window as the previous access that falls in the same aligned 8-byte group completes with zero waits. Otherwise the full wait count applies.
- R10: If the previous access had recovery set (control bit 7) and the new access targets a different window (or no window), one clock with `wait_o` high and all `cs_n` high is inserted before the access phase.
- R11: Configuration writes happen on a clock with `cfg_we` high. `cfg_sel` 0..3 picks a window and 4 picks the defaults. `cfg_field` 0 writes control (bits 3..0 wait, 4 width16, 5 ready enable, 6 burst, 7 recovery, 8 enable, 9 bank-0), 1 writes the 24-bit start, and 2 writes the size code in bits 4..0.
- R12: An access that hits no enabled window uses the wait, width, ready, burst and recovery fields written to the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_ext | input | 1 | Strap sampled in reset; high enables window 0 |
| narrow_bus | input | 1 | Window 0 width pin, high = 8-bit |
| addr | input | 24 | Access address, valid with `cyc_start` |
| cyc_start | input | 1 | One-clock start of a bus cycle |
| rd | input | 1 | Read qualifier |
| wr | input | 1 | Write qualifier |
| rdy | input | 1 | External ready, low stretches the cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window 0..3 or 4 for defaults |
| cfg_field | input | 2 | Register within the selection |
| cfg_wdata | input | 24 | Configuration write data |
| cs_n | output | 4 | Active-low window selects |
| cyc_done | output | 1 | Final clock of the access |
| wait_o | output | 1 | Cycle is being stretched |
| bus16 | output | 1 | Width of the current access, 1 = 16-bit |

## Verification
The bench goes after the window edges: the last address inside a window and the first one past it. A comparator off by one would select the wrong device there. It programs overlapping windows, where a reversed priority encoder would pick the higher-numbered window. It also stalls `rdy` past the wait count, where a design that ignores ready would finish early. Burst accesses inside and across an aligned group catch a design that always or never skips the waits. A switch to another window after a recovery-enabled access catches a missing idle clock, or one with a select still low. Back-to-back accesses to the same window catch a select that glitches high between cycles. A second reset with the boot strap low must leave window 0 dead.

// File: rtl/cswc_pkg.sv
package cswc_pkg;
  localparam int CSW_AW    = 24;
  localparam int CSW_WAITW = 4;
  localparam int CSW_SZW   = 5;

  typedef struct packed {
    logic                 recov;
    logic                 burst;
    logic                 rdy_en;
    logic                 w16;
    logic [CSW_WAITW-1:0] waits;
  } attr_t;

  typedef struct packed {
    logic               en;
    logic               bank0;
    attr_t              attr;
    logic [CSW_AW-1:0]  start;
    logic [CSW_SZW-1:0] sz;
  } win_t;

  // Window hit: base <= a < base + 2^sz
  function automatic logic in_window(input logic [CSW_AW-1:0] a,
                                     input logic [CSW_AW-1:0] base,
                                     input logic [CSW_SZW-1:0] sz);
    logic [CSW_AW:0] d;
    d = {1'b0, a} - {1'b0, base};
    return !d[CSW_AW] && ((d[CSW_AW-1:0] >> sz) == '0);
  endfunction

  // Effective start with optional bank-0 placement
  function automatic logic [CSW_AW-1:0] eff_start(input logic [CSW_AW-1:0] s,
                                                   input logic bank0);
    return bank0 ? {{(CSW_AW-16){1'b0}}, s[15:0]} : s;
  endfunction
endpackage

// File: rtl/cswc_regs.sv
module cswc_regs
  import cswc_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int NBANK  = 3,
  parameter int SELW   = 3,
  parameter logic [CSW_AW-1:0]  BOOT_START = 24'h800000,
  parameter logic [CSW_SZW-1:0] BOOT_SZ    = 5'd23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_ext,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_sel,
  input  logic [1:0]        cfg_field,
  input  logic [CSW_AW-1:0] cfg_wdata,
  output win_t              win [NWIN],
  output attr_t             dflt
);
  localparam attr_t BOOT_ATTR = '{recov: 1'b0, burst: 1'b0, rdy_en: 1'b0, w16: 1'b0, waits: 4'd3};
  localparam attr_t DFLT_RST  = '{recov: 1'b0, burst: 1'b0, rdy_en: 1'b0, w16: 1'b0, waits: 4'd7};

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic HAS_BANK = (i < NBANK);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[i].en    <= (i == 0) ? boot_ext : 1'b0;
        win[i].bank0 <= 1'b0;
        win[i].attr  <= (i == 0) ? BOOT_ATTR : '0;
        win[i].start <= (i == 0) ? BOOT_START : '0;
        win[i].sz    <= (i == 0) ? BOOT_SZ : '0;
      end else if (cfg_we && cfg_sel == SELW'(i)) begin
        case (cfg_field)
          2'd0: begin
            win[i].attr  <= attr_t'(cfg_wdata[7:0]);
            win[i].en    <= cfg_wdata[8];
            win[i].bank0 <= HAS_BANK & cfg_wdata[9];
          end
          2'd1: win[i].start <= cfg_wdata;
          2'd2: win[i].sz    <= cfg_wdata[CSW_SZW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dflt <= DFLT_RST;
    else if (cfg_we && cfg_sel == SELW'(NWIN) && cfg_field == 2'd0)
      dflt <= attr_t'(cfg_wdata[7:0]);
  end
endmodule

// File: rtl/cswc_match.sv
module cswc_match
  import cswc_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int IDXW = 3
) (
  input  logic [CSW_AW-1:0] addr,
  input  win_t              win [NWIN],
  input  attr_t             dflt,
  output logic [IDXW-1:0]   hit_idx,
  output attr_t             hit_attr,
  output logic [NWIN-1:0]   hit_vec
);
  for (genvar i = 0; i < NWIN; i++) begin : g_hit
    assign hit_vec[i] = win[i].en &&
                        in_window(addr, eff_start(win[i].start, win[i].bank0), win[i].sz);
  end

  // lowest index wins
  always_comb begin
    hit_idx  = IDXW'(NWIN);
    hit_attr = dflt;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_idx  = IDXW'(i);
        hit_attr = win[i].attr;
      end
    end
  end
endmodule

// File: rtl/cswc_seq.sv
module cswc_seq
  import cswc_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int IDXW = 3,
  parameter int GRPB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              rd,
  input  logic              wr,
  input  logic              rdy,
  input  logic [CSW_AW-1:0] addr,
  input  logic [IDXW-1:0]   new_idx,
  input  attr_t             new_attr,
  output logic [NWIN-1:0]   cs_n,
  output logic              cyc_done,
  output logic              wait_o,
  output logic              bus16
);
  typedef enum logic [1:0] {S_IDLE, S_REC, S_ACC} st_t;

  st_t                   state;
  attr_t                 cur;
  logic [IDXW-1:0]       cur_idx;
  logic [CSW_WAITW-1:0]  wcnt;
  logic                  have_last, last_rec;
  logic [IDXW-1:0]       last_idx;
  logic [CSW_AW-1:GRPB]  last_grp;

  // named internal events
  logic accept, go, need_rec, burst_skip;

  assign accept     = (state == S_IDLE) || cyc_done;
  assign go         = cyc_start && (rd || wr) && accept;
  assign need_rec   = have_last && last_rec && (new_idx != last_idx);
  assign burst_skip = new_attr.burst && have_last && (new_idx == last_idx) &&
                      (addr[CSW_AW-1:GRPB] == last_grp);
  assign cyc_done   = (state == S_ACC) && (wcnt == '0) && (!cur.rdy_en || rdy);
  assign wait_o     = (state == S_REC) || ((state == S_ACC) && !cyc_done);
  assign bus16      = cur.w16;

  always_comb begin
    cs_n = '1;
    if (state == S_ACC && cur_idx < IDXW'(NWIN))
      cs_n[cur_idx[$clog2(NWIN)-1:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      cur_idx   <= IDXW'(NWIN);
      wcnt      <= '0;
      have_last <= 1'b0;
      last_rec  <= 1'b0;
      last_idx  <= IDXW'(NWIN);
      last_grp  <= '0;
    end else if (go) begin
      cur       <= new_attr;
      cur_idx   <= new_idx;
      wcnt      <= burst_skip ? '0 : new_attr.waits;
      state     <= need_rec ? S_REC : S_ACC;
      have_last <= 1'b1;
      last_rec  <= new_attr.recov;
      last_idx  <= new_idx;
      last_grp  <= addr[CSW_AW-1:GRPB];
    end else if (state == S_REC) begin
      state <= S_ACC;
    end else if (cyc_done) begin
      state <= S_IDLE;
    end else if (state == S_ACC && wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end
  end

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  p_done_wait_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_done && wait_o));
  p_rdy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && cur.rdy_en) |-> rdy);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !go) |=> (cs_n == '1));
  p_rec_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && need_rec) |=> (cs_n == '1 && wait_o));
endmodule

// File: rtl/csel_wait_ctl.sv
module csel_wait_ctl
  import cswc_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int NBANK = 3,
  parameter int GRPB  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_ext,
  input  logic        narrow_bus,
  input  logic [23:0] addr,
  input  logic        cyc_start,
  input  logic        rd,
  input  logic        wr,
  input  logic        rdy,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [1:0]  cfg_field,
  input  logic [23:0] cfg_wdata,
  output logic [3:0]  cs_n,
  output logic        cyc_done,
  output logic        wait_o,
  output logic        bus16
);
  localparam int IDXW = $clog2(NWIN + 1);

  win_t            win_raw [NWIN];
  win_t            win_eff [NWIN];
  attr_t           dflt, hit_attr;
  logic [IDXW-1:0] hit_idx;
  logic [NWIN-1:0] hit_vec;

  cswc_regs #(.NWIN(NWIN), .NBANK(NBANK), .SELW(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .win(win_raw), .dflt(dflt));

  // window 0 width follows the pin
  for (genvar i = 0; i < NWIN; i++) begin : g_eff
    always_comb begin
      win_eff[i] = win_raw[i];
      if (i == 0) win_eff[i].attr.w16 = ~narrow_bus;
    end
  end

  cswc_match #(.NWIN(NWIN), .IDXW(IDXW)) u_match (
    .addr(addr), .win(win_eff), .dflt(dflt),
    .hit_idx(hit_idx), .hit_attr(hit_attr), .hit_vec(hit_vec));

  cswc_seq #(.NWIN(NWIN), .IDXW(IDXW), .GRPB(GRPB)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rd(rd), .wr(wr),
    .rdy(rdy), .addr(addr), .new_idx(hit_idx), .new_attr(hit_attr),
    .cs_n(cs_n), .cyc_done(cyc_done), .wait_o(wait_o), .bus16(bus16));

  // R1: reported index is the lowest set hit
  p_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> (hit_vec[hit_idx[$clog2(NWIN)-1:0]] &&
                         ((hit_vec & ((NWIN'(1) << hit_idx) - 1'b1)) == '0)));
endmodule

// File: tb/sim_csel_wait_ctl.sv
module sim_csel_wait_ctl;
  logic        clk = 0, rst_n = 0, boot_ext = 1, narrow_bus = 0;
  logic [23:0] addr = '0;
  logic        cyc_start = 0, rd = 0, wr = 0, rdy = 1;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_field = '0;
  logic [23:0] cfg_wdata = '0;
  logic [3:0]  cs_n;
  logic        cyc_done, wait_o, bus16;

  csel_wait_ctl u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int         t0;
    int         lat;
    logic [3:0] cs;
    logic       w16;
    string      tag;
  } item_t;
  item_t q[$];

  int cnt = 0, checks = 0, errors = 0;
  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every done
  always @(negedge clk) begin
    if (rst_n && cyc_done) begin
      if (q.size() == 0) chk(0, "unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(cnt - it.t0 == it.lat, {it.tag, " latency"}, cnt - it.t0, it.lat);
        chk(cs_n == it.cs, {it.tag, " cs_n"}, cs_n, it.cs);
        chk(bus16 == it.w16, {it.tag, " bus16"}, bus16, it.w16);
      end
    end
  end

  task automatic cfg(input logic [2:0] s, input logic [1:0] f, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_field = f; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic run(input logic [23:0] a, input int lat, input logic [3:0] cs,
                     input logic w16, input string tag, input bit b2b);
    item_t it;
    if (b2b) begin
      forever begin @(negedge clk); #1; if (cyc_done) break; end
    end else begin
      forever begin @(negedge clk); #1; if (!wait_o && !cyc_done) break; end
    end
    addr = a; cyc_start = 1; rd = 1;
    @(posedge clk); #1;
    it.t0 = cnt; it.lat = lat; it.cs = cs; it.w16 = w16; it.tag = tag;
    q.push_back(it);
    cyc_start = 0; rd = 0;
  endtask

  task automatic drain();
    forever begin @(negedge clk); #1; if (q.size() == 0 && !wait_o && !cyc_done) break; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cs_n == 4'hF && !wait_o && !cyc_done, "R6 reset outputs", {cs_n, wait_o, cyc_done}, 6'h3C);

    // R6 boot window, R3 waits, R5 pin width
    run(24'h812345, 3, 4'hE, 1'b1, "R6 boot window", 0);
    drain();
    narrow_bus = 1;
    run(24'h812346, 3, 4'hE, 1'b0, "R5 pin narrow", 0);
    drain();

    // R12 / R11 defaults: wait 1, 8-bit
    cfg(3'd4, 2'd0, 24'h000001);
    run(24'h001000, 1, 4'hF, 1'b0, "R12 default attrs", 0);

    // R1 window 1: 0x100000 size 2^16, wait 2, 16-bit
    cfg(3'd1, 2'd1, 24'h100000);
    cfg(3'd1, 2'd2, 24'd16);
    cfg(3'd1, 2'd0, 24'h112);
    run(24'h10FFFE, 2, 4'hD, 1'b1, "R1 last inside", 0);
    run(24'h110000, 1, 4'hF, 1'b0, "R1 first past end", 0);
    run(24'h0FFFFF, 1, 4'hF, 1'b0, "R1 below start", 0);

    // R1 overlap priority: window 2 inside window 1
    cfg(3'd2, 2'd1, 24'h108000);
    cfg(3'd2, 2'd2, 24'd12);
    cfg(3'd2, 2'd0, 24'h105);
    run(24'h108010, 2, 4'hD, 1'b1, "R1 priority", 0);
    cfg(3'd1, 2'd0, 24'h012);
    run(24'h108010, 5, 4'hB, 1'b0, "R2 window2 after disable", 0);

    // R4 ready on window 3
    cfg(3'd3, 2'd1, 24'h200000);
    cfg(3'd3, 2'd2, 24'd8);
    cfg(3'd3, 2'd0, 24'h121);
    run(24'h200004, 1, 4'h7, 1'b0, "R4 ready high", 0);
    drain();
    rdy = 0;
    run(24'h200006, 4, 4'h7, 1'b0, "R4 ready stall", 0);
    repeat (4) @(posedge clk);
    #1 rdy = 1;
    drain();

    // R7 bank-0 placement
    cfg(3'd2, 2'd1, 24'h348000);
    cfg(3'd2, 2'd0, 24'h305);
    run(24'h008004, 5, 4'hB, 1'b0, "R7 bank0 hit", 0);
    run(24'h348004, 1, 4'hF, 1'b0, "R7 raw start not used", 0);
    cfg(3'd3, 2'd0, 24'h321);
    run(24'h200010, 1, 4'h7, 1'b0, "R7 window3 ignores bank bit", 0);

    // R8 back to back same window
    cfg(3'd1, 2'd0, 24'h112);
    run(24'h100100, 2, 4'hD, 1'b1, "R8 first", 0);
    run(24'h100102, 2, 4'hD, 1'b1, "R8 second", 1);
    @(negedge clk);
    chk(cs_n == 4'hD, "R8 cs held", cs_n, 4'hD);
    drain();
    @(negedge clk);
    chk(cs_n == 4'hF, "R8 release", cs_n, 4'hF);

    // R9 burst on window 1
    cfg(3'd1, 2'd0, 24'h152);
    run(24'h001000, 1, 4'hF, 1'b0, "R9 elsewhere", 0);
    run(24'h100000, 2, 4'hD, 1'b1, "R9 first", 0);
    run(24'h100002, 0, 4'hD, 1'b1, "R9 sequential", 0);
    run(24'h100008, 2, 4'hD, 1'b1, "R9 next group", 0);

    // R10 recovery on window 3
    cfg(3'd3, 2'd0, 24'h180);
    run(24'h200000, 0, 4'h7, 1'b0, "R10 w3 first", 0);
    run(24'h200002, 0, 4'h7, 1'b0, "R10 same window", 0);
    run(24'h100004, 3, 4'hD, 1'b1, "R10 switch", 0);
    @(negedge clk);
    chk(cs_n == 4'hF && wait_o, "R10 idle clock", {cs_n, wait_o}, 5'h1F);
    drain();

    // R6 reset with strap low
    boot_ext = 0;
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    run(24'h812345, 7, 4'hF, 1'b0, "R6 strap low", 0);
    drain();
    chk(q.size() == 0, "scoreboard empty", q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule